// File: doc/BRIEF.md
# Counter Read-Back Latch Controller

This block sits between a CPU byte bus and three free-running counter channels. A write to the control address in the right format is a read-back command. The command can freeze the 16-bit count, the 8-bit status, or both, for any mix of the three channels. Each frozen value stays put until the CPU has read it, whatever the live channel does in the meantime. After that read the channel's read path follows the live value again.

Reads of a channel return a frozen status byte first, if one is pending. The count comes after it, low byte and then high byte. A count that is not frozen is read live, in the same two-byte order. Counter arithmetic and the pad-level tri-state drivers are outside this block. The block reports which cycles it drives the bus through `rdata_oe`.

Top module: `rb_latch_ctrl`

## Requirements
- R1: A write is a read-back command only when `addr` is 3, `wdata[7:6]` is 2'b11 and `wdata[0]` is 0. Every other write has no effect on any latch or byte order.
- R2: In a command, `wdata[1]`, `wdata[2]` and `wdata[3]` name channels 0, 1 and 2. Any combination may be named, and every named channel is serviced in the same cycle.
- R3: `wdata[5]` low freezes the count of each named channel at its value in the command cycle. The next count read is then the low byte. The frozen count holds until its high byte has been read, after which reads follow the live count.
- R4: `wdata[4]` low freezes the status of each named channel at its value in the command cycle. It holds until one read of that channel consumes it.
- R5: A latch request for a channel whose latch of that kind is still unread is ignored. It does not change the held value. Other channels in the same command are still latched.
- R6: A command that asks for both count and status, on a channel whose status is already pending, latches only the count.
- R7: With status and count both pending, reads of the channel return status, then the count low byte, then the count high byte.
- R8: A channel with nothing latched returns the live count, low byte and high byte on alternate reads.
- R9: A read drives the bus (`rdata_oe` high) only when `cs_n` is low, `rd_n` is low, `wr_n` is high and `addr` is not 3. Otherwise `rdata` is 0, and no latch or byte order changes. Writes are taken only when `cs_n` is low, `wr_n` is low and `rd_n` is high.
- R10: Reset clears every pending latch and returns every channel's byte order to the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low, one access per cycle |
| wr_n | input | 1 | Write strobe, active low, one access per cycle |
| addr | input | 2 | 0..2 select a channel, 3 the control address |
| wdata | input | 8 | Write data byte |
| cnt_live | input | 48 | Live counts, channel n in bits 16n+15..16n |
| stat_live | input | 24 | Live status words, channel n in bits 8n+7..8n |
| rdata | output | 8 | Read data byte, 0 when not driving |
| rdata_oe | output | 1 | High while the block drives the bus |

## Verification
Two of the block's actions can fall in one command cycle: servicing a channel and refusing a channel whose latch is still unread. The same holds for a fresh count latch and a refused status latch on a single channel. The bench provokes both cases. It leaves one channel's status unread, changes the live values, and then issues a single command naming that channel together with another channel, or asking for count and status together. It then reads the channels back. Each read is judged against the value that was live when that latch was first taken and the value live at the new command.

// File: rtl/rb_latch_ctrl.sv
module rb_latch_ctrl #(
  parameter int NCH = 3,
  parameter int CW  = 16,
  parameter int SW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  input  logic [NCH*CW-1:0] cnt_live,
  input  logic [NCH*SW-1:0] stat_live,
  output logic [7:0]        rdata,
  output logic              rdata_oe
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic rd_act, wr_act, cmd;
  logic [NCH-1:0] cnt_lat, stat_lat, byte_hi, rd_ch;
  logic [NCH-1:0][CW-1:0] cnt_hold;
  logic [NCH-1:0][SW-1:0] stat_hold;
  logic [NCH-1:0][7:0]    ch_byte;

  assign rd_act = !cs_n && !rd_n && wr_n;
  assign wr_act = !cs_n && !wr_n && rd_n;
  assign cmd    = wr_act && addr == CTRL_ADDR && wdata[7:6] == 2'b11 && !wdata[0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          cl, sl, hp;
    logic [CW-1:0] ch, cur;
    logic [SW-1:0] sh;
    wire           sel = cmd && wdata[i+1];

    assign rd_ch[i] = rd_act && addr == i[1:0];
    assign cur      = cl ? ch : cnt_live[CW*i +: CW];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cl <= 1'b0;
        sl <= 1'b0;
        hp <= 1'b0;
        ch <= '0;
        sh <= '0;
      end else if (sel) begin
        if (!wdata[5] && !cl) begin
          cl <= 1'b1;
          ch <= cnt_live[CW*i +: CW];
          hp <= 1'b0;
        end
        if (!wdata[4] && !sl) begin
          sl <= 1'b1;
          sh <= stat_live[SW*i +: SW];
        end
      end else if (rd_ch[i]) begin
        if (sl) sl <= 1'b0;
        else begin
          hp <= !hp;
          if (hp) cl <= 1'b0;
        end
      end
    end

    assign cnt_lat[i]   = cl;
    assign stat_lat[i]  = sl;
    assign byte_hi[i]   = hp;
    assign cnt_hold[i]  = ch;
    assign stat_hold[i] = sh;
    assign ch_byte[i]   = sl ? sh : (hp ? cur[15:8] : cur[7:0]);
  end

  assign rdata_oe = rd_act && addr != CTRL_ADDR;
  assign rdata    = rdata_oe ? ch_byte[addr] : 8'h00;
endmodule

// File: rtl/rb_latch_ctrl_chk.sv
module rb_latch_ctrl_chk #(
  parameter int NCH = 3,
  parameter int CW  = 16,
  parameter int SW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   rd_n,
  input logic                   wr_n,
  input logic [1:0]             addr,
  input logic [7:0]             wdata,
  input logic [NCH*CW-1:0]      cnt_live,
  input logic [NCH*SW-1:0]      stat_live,
  input logic [7:0]             rdata,
  input logic                   rdata_oe,
  input logic [NCH-1:0]         cnt_lat,
  input logic [NCH-1:0]         stat_lat,
  input logic [NCH-1:0]         byte_hi,
  input logic [NCH-1:0][CW-1:0] cnt_hold,
  input logic [NCH-1:0][SW-1:0] stat_hold
);
  wire rd_ok  = !cs_n && !rd_n && wr_n;
  wire cmd_ok = !cs_n && !wr_n && rd_n && addr == 2'd3
                && wdata[7:6] == 2'b11 && !wdata[0];

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (cnt_lat == '0 && stat_lat == '0 && byte_hi == '0));

  assert_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n || !wr_n || addr == 2'd3) |-> (!rdata_oe && rdata == 8'h00));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    wire rdc = rd_ok && addr == i[1:0];

    assert_stat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_lat[i] && !rdc) |=> (stat_lat[i] && $stable(stat_hold[i])));

    assert_stat_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rdc && stat_lat[i]) |=> !stat_lat[i]);

    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_lat[i] && !rdc) |=> (cnt_lat[i] && $stable(cnt_hold[i])));

    assert_cnt_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ok && wdata[i+1] && !wdata[5] && !cnt_lat[i])
        |=> (cnt_lat[i] && !byte_hi[i] && cnt_hold[i] == $past(cnt_live[CW*i +: CW])));

    assert_status_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rdc && stat_lat[i]) |-> (rdata_oe && rdata == stat_hold[i]));

    assert_frozen_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rdc && !stat_lat[i] && cnt_lat[i])
        |-> (rdata == (byte_hi[i] ? cnt_hold[i][15:8] : cnt_hold[i][7:0])));
  end
endmodule

bind rb_latch_ctrl rb_latch_ctrl_chk #(.NCH(NCH), .CW(CW), .SW(SW)) chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .addr(addr), .wdata(wdata), .cnt_live(cnt_live), .stat_live(stat_live),
  .rdata(rdata), .rdata_oe(rdata_oe), .cnt_lat(cnt_lat), .stat_lat(stat_lat),
  .byte_hi(byte_hi), .cnt_hold(cnt_hold), .stat_hold(stat_hold)
);

// File: tb/rb_latch_ctrl_test.sv
module rb_latch_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [15:0] c0 = 16'h1234, c1 = 16'hABCD, c2 = 16'h0F0E;
  logic [7:0]  s0 = 8'h81, s1 = 8'h42, s2 = 8'h23;
  logic [7:0] rdata;
  logic rdata_oe;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [7:0] q_d[$];
  logic       q_oe[$];
  string      q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rb_latch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .cnt_live({c2, c1, c0}),
    .stat_live({s2, s1, s0}), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit csn = 1'b0);
    @(posedge clk); #1;
    cs_n = csn; wr_n = 1'b0; addr = a; wdata = d;
    @(posedge clk); #1;
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] ed, input logic eoe,
                    input string tag, input bit csn = 1'b0, input bit wlow = 1'b0);
    @(posedge clk); #1;
    cs_n = csn; rd_n = 1'b0; wr_n = !wlow; addr = a;
    q_d.push_back(ed); q_oe.push_back(eoe); q_tag.push_back(tag);
    @(posedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  logic [7:0] m_d;
  logic       m_oe;
  string      m_tag;
  always @(negedge clk) begin
    if (q_d.size() > 0) begin
      m_d = q_d.pop_front(); m_oe = q_oe.pop_front(); m_tag = q_tag.pop_front();
      checks++;
      if (rdata !== m_d || rdata_oe !== m_oe) begin
        failures++;
        $display("FAIL %s: rdata=%02h oe=%0b expected rdata=%02h oe=%0b",
                 m_tag, rdata, rdata_oe, m_d, m_oe);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R10: nothing latched after reset, live count low then high
    rd(0, 8'h34, 1, "R10 reset live low");
    rd(0, 8'h12, 1, "R10 reset live high");
    // R3: count latch of channel 0
    wr(3, 8'hD2); c0 = 16'h5555;
    rd(0, 8'h34, 1, "R3 frozen low");
    rd(0, 8'h12, 1, "R3 frozen high");
    rd(0, 8'h55, 1, "R3 released low");
    rd(0, 8'h55, 1, "R8 live high");
    // R7: status and count on channel 1
    wr(3, 8'hC4); c1 = 16'h1111; s1 = 8'h00;
    rd(1, 8'h42, 1, "R7 status first");
    rd(1, 8'hCD, 1, "R7 count low");
    rd(1, 8'hAB, 1, "R7 count high");
    rd(1, 8'h11, 1, "R8 live after release");
    rd(1, 8'h11, 1, "R8 live high");
    // R5: repeat status latch on ch2 ignored, ch1 serviced in same command
    wr(3, 8'hE8); s2 = 8'h99;
    wr(3, 8'hEC); s1 = 8'h77;
    rd(2, 8'h23, 1, "R5 ch2 kept first status");
    rd(1, 8'h00, 1, "R5 ch1 serviced");
    rd(2, 8'h0E, 1, "R5 ch2 live low");
    rd(2, 8'h0F, 1, "R5 ch2 live high");
    // R6: count+status with status pending latches count only
    wr(3, 8'hE2); s0 = 8'h66; c0 = 16'h2468;
    wr(3, 8'hC2); c0 = 16'h9999;
    rd(0, 8'h81, 1, "R6 old status");
    rd(0, 8'h68, 1, "R6 count low");
    rd(0, 8'h24, 1, "R6 count high");
    rd(0, 8'h99, 1, "R6 released low");
    rd(0, 8'h99, 1, "R8 live high");
    // R2: all three channels in one command
    wr(3, 8'hDE); c0 = 16'h0000; c1 = 16'h0000; c2 = 16'h0000;
    rd(0, 8'h99, 1, "R2 ch0 low");
    rd(0, 8'h99, 1, "R2 ch0 high");
    rd(1, 8'h11, 1, "R2 ch1 low");
    rd(1, 8'h11, 1, "R2 ch1 high");
    rd(2, 8'h0E, 1, "R2 ch2 low");
    rd(2, 8'h0F, 1, "R2 ch2 high");
    // R1: malformed commands and channel writes have no effect
    wr(3, 8'hD3); wr(3, 8'h12); wr(0, 8'hC2);
    c0 = 16'h4321;
    rd(0, 8'h21, 1, "R1 no latch low");
    rd(0, 8'h43, 1, "R1 no latch high");
    // R9: deselected or invalid accesses ignored
    wr(3, 8'hD2, 1'b1); c0 = 16'h8765;
    rd(0, 8'h00, 0, "R9 cs high read", 1'b1);
    rd(3, 8'h00, 0, "R9 control read");
    rd(0, 8'h00, 0, "R9 both strobes", 1'b0, 1'b1);
    rd(0, 8'h65, 1, "R9 live low, order unchanged");
    rd(0, 8'h87, 1, "R9 live high");
    // R10: reset mid-sequence clears latches and byte order
    wr(3, 8'hC2); c0 = 16'h1357; s0 = 8'h55;
    rd(0, 8'h66, 1, "R10 pre status");
    rd(0, 8'h65, 1, "R10 pre frozen low");
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk); #1 rst_n = 1'b1;
    c0 = 16'h3344;
    rd(0, 8'h44, 1, "R10 after reset low");
    rd(0, 8'h33, 1, "R10 after reset high");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule